// File: doc/BRIEF.md
# Iterative Divide and Square-Root Unit

This functional unit performs one long-latency arithmetic operation at a time. The supported operations are single-precision floating-point divide, floating-point square root, and integer quotient or remainder in signed and unsigned forms. The unit has no pipeline. A caller raises `start_i` with an opcode, two 32-bit operands and a tag. The unit then holds `busy_o` high until the result is ready. After that it pulses `done_o` for one cycle, with the result and the returned tag on registered outputs.

One shift-subtract recurrence serves every operation. Divisions bring down one dividend bit per step. Square root brings down two radicand bits per step and tests against the partial root. The recurrence runs two steps per clock. A separate latency counter then pads the run, so each opcode finishes at a fixed and exactly known cycle count whatever the operand values are. Floating-point handling covers normal numbers, with truncation. Zero divisors, zero operands, negative square roots and exponent overflow or underflow each produce a fixed defined value. The unit never raises a trap.

Top module: `divsqrt_unit`

## Requirements
- R1: While `busy_o` is high, `start_i` is ignored. It does not change the running operation's result, tag or latency, and it produces no extra `done_o` pulse.
- R2: A start is accepted when `start_i` is high, `busy_o` is low and the opcode is valid. `busy_o` is high from the cycle after acceptance until `done_o`. `done_o` is a one-cycle pulse during which `busy_o` is low, and a new start may be accepted on that cycle.
- R3: If the accepting clock edge is edge 0, `done_o` is high just after edge L. L is set by the opcode: 0 = float divide (L=17), 1 = float square root (L=16), 2 = signed quotient (L=22), 3 = unsigned quotient (L=22), 4 = signed remainder (L=23), 5 = unsigned remainder (L=23).
- R4: Opcodes 6 and 7 are invalid. A start carrying one of them is dropped and `busy_o` stays low.
- R5: `tag_o` returns the tag given at acceptance, in the same cycle as `done_o`. `result_o` and `tag_o` hold their values until the next `done_o`.
- R6: Unsigned quotient and remainder are floor(a/b) and a mod b.
- R7: A signed quotient truncates toward zero, and a signed remainder takes the sign of the dividend. 0x80000000 divided by -1 gives quotient 0x80000000 and remainder 0.
- R8: For an integer divisor of zero, the quotient is 0xFFFFFFFF and the remainder equals the dividend, in both signed and unsigned forms.
- R9: Float divide of normal operands works as follows. The sign is the XOR of the operand signs. With significands ma and mb (hidden bit set), Q = floor(ma·2^26/mb). If Q bit 26 is set, the fraction is Q[25:3] and the biased exponent is ea−eb+127. Otherwise the fraction is Q[24:2] and the exponent is ea−eb+126.
- R10: Float divide special cases are these. A divisor with exponent field 0 gives a signed infinity (sign bit, 0xFF, zero fraction). Otherwise a dividend with exponent field 0 gives a signed zero. A computed exponent of 255 or more gives a signed infinity, and one of 0 or less gives a signed zero.
- R11: Float square root of a positive normal x with unbiased exponent e works as follows. R = ma·2^23 if e is even, or ma·2^24 if e is odd. The result is {0, floor(e/2)+127, low 23 bits of floor(sqrt(R))}.
- R12: Float square root of a negative normal returns 0x7FC00000. An input with exponent field 0 returns its own sign followed by 31 zero bits.
- R13: After reset, `busy_o`, `done_o`, `result_o` and `tag_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to begin an operation |
| op_i | input | 3 | Opcode (encodings in R3) |
| a_i | input | 32 | Dividend or radicand |
| b_i | input | 32 | Divisor (ignored for square root) |
| tag_i | input | TAG_W | Caller tag, returned with the result |
| busy_o | output | 1 | Operation in flight |
| done_o | output | 1 | One-cycle result-valid pulse |
| result_o | output | 32 | Result of the last completed operation |
| tag_o | output | TAG_W | Tag of the last completed operation |

## Verification
The hardest case to reach from the ports is a start request that arrives while an operation is in flight. To count as a real test, that request must carry a different opcode and tag, and it must stay asserted across several cycles of the busy window. The stimulus holds such a request over four busy cycles of an unsigned quotient. The scoreboard then requires exactly one completion, with the original tag, value and latency, and watches for stray pulses for a further stretch. Back-to-back issue on the `done_o` cycle comes naturally from a driver that waits only for `busy_o` to fall.

// File: rtl/divsqrt_pkg.sv
`timescale 1ns/1ps
package divsqrt_pkg;
  localparam int DW          = 32;
  localparam int REM_W       = DW + 2;
  localparam int SH_W        = 2 * DW;
  localparam int MANT_W      = 23;
  localparam int SIG_W       = MANT_W + 1;
  localparam int FDIV_STEPS  = SIG_W + 2;
  localparam int FSQRT_STEPS = SIG_W;
  localparam int INT_STEPS   = DW;
  localparam int STEP_W      = $clog2(INT_STEPS + 1);

  typedef enum logic [2:0] {
    OP_FDIV  = 3'd0,
    OP_FSQRT = 3'd1,
    OP_SDIV  = 3'd2,
    OP_UDIV  = 3'd3,
    OP_SREM  = 3'd4,
    OP_UREM  = 3'd5
  } dsq_op_e;

  typedef struct packed {
    logic          sign;
    logic [9:0]    exp;
    logic          special;
    logic [DW-1:0] spec_val;
    logic          neg_q;
    logic          neg_r;
    logic          dbz;
    logic [DW-1:0] a_raw;
  } dsq_aux_t;

  function automatic logic op_is_valid(logic [2:0] op);
    return op <= 3'd5;
  endfunction
endpackage

// File: rtl/dsq_prep.sv
`timescale 1ns/1ps
module dsq_prep
  import divsqrt_pkg::*;
(
  input  dsq_op_e            op,
  input  logic [DW-1:0]      a,
  input  logic [DW-1:0]      b,
  output logic [REM_W-1:0]   rem0,
  output logic [DW-1:0]      q0,
  output logic [SH_W-1:0]    sh0,
  output logic [DW-1:0]      d0,
  output logic               is_sqrt,
  output logic [STEP_W-1:0]  steps,
  output dsq_aux_t           aux
);
  logic [SIG_W-1:0] ma, mb;
  logic [7:0]       ea, eb;
  logic [DW-1:0]    a_mag, b_mag;
  logic signed [9:0] e_unb, e_half;
  logic [2*SIG_W-1:0] rad;

  always_comb begin
    ma     = {1'b1, a[MANT_W-1:0]};
    mb     = {1'b1, b[MANT_W-1:0]};
    ea     = a[30:23];
    eb     = b[30:23];
    a_mag  = a[DW-1] ? (~a + 1'b1) : a;
    b_mag  = b[DW-1] ? (~b + 1'b1) : b;
    e_unb  = $signed({2'b00, ea}) - 10'sd127;
    e_half = e_unb >>> 1;
    rad    = ea[0] ? {1'b0, ma, {MANT_W{1'b0}}} : {ma, {SIG_W{1'b0}}};

    rem0    = '0;
    q0      = '0;
    sh0     = '0;
    d0      = '0;
    is_sqrt = 1'b0;
    steps   = '0;
    aux     = '0;

    unique case (op)
      OP_FDIV: begin
        d0       = {{(DW-SIG_W){1'b0}}, mb};
        steps    = STEP_W'(FDIV_STEPS);
        aux.sign = a[DW-1] ^ b[DW-1];
        aux.exp  = 10'($signed({2'b00, ea}) - $signed({2'b00, eb}) + 10'sd126);
        if (ma >= mb) begin
          rem0 = {{(REM_W-SIG_W){1'b0}}, ma - mb};
          q0   = {{(DW-1){1'b0}}, 1'b1};
        end else begin
          rem0 = {{(REM_W-SIG_W){1'b0}}, ma};
        end
        if (eb == 8'd0) begin
          aux.special  = 1'b1;
          aux.spec_val = {aux.sign, 8'hFF, {MANT_W{1'b0}}};
        end else if (ea == 8'd0) begin
          aux.special  = 1'b1;
          aux.spec_val = {aux.sign, {(DW-1){1'b0}}};
        end
      end
      OP_FSQRT: begin
        is_sqrt = 1'b1;
        steps   = STEP_W'(FSQRT_STEPS);
        sh0     = {rad, {(SH_W-2*SIG_W){1'b0}}};
        aux.exp = 10'(e_half + 10'sd127);
        if (ea == 8'd0) begin
          aux.special  = 1'b1;
          aux.spec_val = {a[DW-1], {(DW-1){1'b0}}};
        end else if (a[DW-1]) begin
          aux.special  = 1'b1;
          aux.spec_val = 32'h7FC0_0000;
        end
      end
      OP_SDIV, OP_SREM: begin
        sh0       = {a_mag, {DW{1'b0}}};
        d0        = b_mag;
        steps     = STEP_W'(INT_STEPS);
        aux.neg_q = a[DW-1] ^ b[DW-1];
        aux.neg_r = a[DW-1];
        aux.dbz   = (b == '0);
        aux.a_raw = a;
      end
      default: begin
        sh0       = {a, {DW{1'b0}}};
        d0        = b;
        steps     = STEP_W'(INT_STEPS);
        aux.dbz   = (b == '0);
        aux.a_raw = a;
      end
    endcase
  end
endmodule

// File: rtl/dsq_step.sv
`timescale 1ns/1ps
module dsq_step
  import divsqrt_pkg::*;
(
  input  logic             is_sqrt,
  input  logic [REM_W-1:0] rem_i,
  input  logic [DW-1:0]    q_i,
  input  logic [SH_W-1:0]  sh_i,
  input  logic [DW-1:0]    d_i,
  output logic [REM_W-1:0] rem_o,
  output logic [DW-1:0]    q_o,
  output logic [SH_W-1:0]  sh_o
);
  logic [REM_W-1:0] shifted, trial;

  always_comb begin
    if (is_sqrt) begin
      shifted = {rem_i[REM_W-3:0], sh_i[SH_W-1 -: 2]};
      sh_o    = sh_i << 2;
      trial   = {q_i, 2'b01};
    end else begin
      shifted = {rem_i[REM_W-2:0], sh_i[SH_W-1]};
      sh_o    = sh_i << 1;
      trial   = {2'b00, d_i};
    end
    if (shifted >= trial) begin
      rem_o = shifted - trial;
      q_o   = {q_i[DW-2:0], 1'b1};
    end else begin
      rem_o = shifted;
      q_o   = {q_i[DW-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/dsq_post.sv
`timescale 1ns/1ps
module dsq_post
  import divsqrt_pkg::*;
(
  input  dsq_op_e        op,
  input  logic [DW-1:0]  q,
  input  logic [DW-1:0]  rem,
  input  dsq_aux_t       aux,
  output logic [DW-1:0]  res
);
  logic              norm;
  logic [MANT_W-1:0] mant;
  logic [9:0]        e_adj;

  always_comb begin
    norm  = q[FDIV_STEPS];
    mant  = norm ? q[FDIV_STEPS-1 -: MANT_W] : q[FDIV_STEPS-2 -: MANT_W];
    e_adj = aux.exp + {9'b0, norm};
    res   = '0;
    unique case (op)
      OP_FDIV: begin
        if (aux.special)                 res = aux.spec_val;
        else if ($signed(e_adj) >= 10'sd255) res = {aux.sign, 8'hFF, {MANT_W{1'b0}}};
        else if ($signed(e_adj) <= 10'sd0)   res = {aux.sign, {(DW-1){1'b0}}};
        else                             res = {aux.sign, e_adj[7:0], mant};
      end
      OP_FSQRT: res = aux.special ? aux.spec_val : {1'b0, aux.exp[7:0], q[MANT_W-1:0]};
      OP_SDIV:  res = aux.dbz ? '1 : (aux.neg_q ? (~q + 1'b1) : q);
      OP_UDIV:  res = aux.dbz ? '1 : q;
      OP_SREM:  res = aux.dbz ? aux.a_raw : (aux.neg_r ? (~rem + 1'b1) : rem);
      default:  res = aux.dbz ? aux.a_raw : rem;
    endcase
  end
endmodule

// File: rtl/divsqrt_unit.sv
`timescale 1ns/1ps
module divsqrt_unit
  import divsqrt_pkg::*;
#(
  parameter int TAG_W         = 4,
  parameter int LAT_FDIV      = 17,
  parameter int LAT_FSQRT     = 16,
  parameter int LAT_IDIV      = 22,
  parameter int LAT_IREM      = 23,
  parameter int STEPS_PER_CYC = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [2:0]       op_i,
  input  logic [DW-1:0]    a_i,
  input  logic [DW-1:0]    b_i,
  input  logic [TAG_W-1:0] tag_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [DW-1:0]    result_o,
  output logic [TAG_W-1:0] tag_o
);
  localparam int LAT_MAX = (LAT_IREM > LAT_IDIV) ? LAT_IREM : LAT_IDIV;
  localparam int CNT_W   = $clog2(LAT_MAX + 1);

  function automatic logic [CNT_W-1:0] lat_m1(dsq_op_e op);
    case (op)
      OP_FDIV:          return CNT_W'(LAT_FDIV - 1);
      OP_FSQRT:         return CNT_W'(LAT_FSQRT - 1);
      OP_SDIV, OP_UDIV: return CNT_W'(LAT_IDIV - 1);
      default:          return CNT_W'(LAT_IREM - 1);
    endcase
  endfunction

  logic              busy_q, done_q, sqrt_q;
  logic [DW-1:0]     res_q, q_q, d_q;
  logic [TAG_W-1:0]  tag_q, tag_out_q;
  dsq_op_e           op_q, op_in;
  logic [CNT_W-1:0]  lat_cnt;
  logic [STEP_W-1:0] step_cnt;
  logic [REM_W-1:0]  rem_q;
  logic [SH_W-1:0]   sh_q;
  dsq_aux_t          aux_q;

  logic              accept;
  logic [REM_W-1:0]  rem0;
  logic [DW-1:0]     q0, d0, post_res;
  logic [SH_W-1:0]   sh0;
  logic              sqrt0;
  logic [STEP_W-1:0] steps0;
  dsq_aux_t          aux0;

  assign op_in  = dsq_op_e'(op_i);
  assign accept = start_i && !busy_q && op_is_valid(op_i);

  dsq_prep u_prep (
    .op(op_in), .a(a_i), .b(b_i), .rem0(rem0), .q0(q0), .sh0(sh0),
    .d0(d0), .is_sqrt(sqrt0), .steps(steps0), .aux(aux0)
  );

  logic [REM_W-1:0] rem_c [STEPS_PER_CYC+1];
  logic [DW-1:0]    q_c   [STEPS_PER_CYC+1];
  logic [SH_W-1:0]  sh_c  [STEPS_PER_CYC+1];

  assign rem_c[0] = rem_q;
  assign q_c[0]   = q_q;
  assign sh_c[0]  = sh_q;

  for (genvar g = 0; g < STEPS_PER_CYC; g++) begin : g_chain
    dsq_step u_step (
      .is_sqrt(sqrt_q), .rem_i(rem_c[g]), .q_i(q_c[g]), .sh_i(sh_c[g]),
      .d_i(d_q), .rem_o(rem_c[g+1]), .q_o(q_c[g+1]), .sh_o(sh_c[g+1])
    );
  end

  dsq_post u_post (
    .op(op_q), .q(q_q), .rem(rem_q[DW-1:0]), .aux(aux_q), .res(post_res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      res_q     <= '0;
      tag_q     <= '0;
      tag_out_q <= '0;
      op_q      <= OP_FDIV;
      lat_cnt   <= '0;
      step_cnt  <= '0;
      rem_q     <= '0;
      q_q       <= '0;
      sh_q      <= '0;
      d_q       <= '0;
      sqrt_q    <= 1'b0;
      aux_q     <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q   <= 1'b1;
        op_q     <= op_in;
        tag_q    <= tag_i;
        lat_cnt  <= lat_m1(op_in);
        step_cnt <= steps0;
        rem_q    <= rem0;
        q_q      <= q0;
        sh_q     <= sh0;
        d_q      <= d0;
        sqrt_q   <= sqrt0;
        aux_q    <= aux0;
      end else if (busy_q) begin
        if (step_cnt != '0) begin
          rem_q    <= rem_c[STEPS_PER_CYC];
          q_q      <= q_c[STEPS_PER_CYC];
          sh_q     <= sh_c[STEPS_PER_CYC];
          step_cnt <= step_cnt - STEP_W'(STEPS_PER_CYC);
        end
        if (lat_cnt == '0) begin
          busy_q    <= 1'b0;
          done_q    <= 1'b1;
          res_q     <= post_res;
          tag_out_q <= tag_q;
        end else begin
          lat_cnt <= lat_cnt - 1'b1;
        end
      end
    end
  end

  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign result_o = res_q;
  assign tag_o    = tag_out_q;

  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (rst)
    accept |=> busy_o);
  assert_done_one_cycle_R2: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  assert_done_not_busy_R2: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);
  assert_busy_ends_in_done_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> done_o);
  assert_engine_idle_at_finish_R3: assert property (@(posedge clk) disable iff (rst)
    (busy_q && lat_cnt == '0) |-> (step_cnt == '0));
  assert_bad_opcode_dropped_R4: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o && !op_is_valid(op_i)) |=> !busy_o);
  assert_outputs_held_R5: assert property (@(posedge clk) disable iff (rst)
    !done_o |=> ($stable(tag_o) || done_o));
endmodule

// File: tb/divsqrt_unit_bench.sv
`timescale 1ns/1ps
module divsqrt_unit_bench;
  import divsqrt_pkg::*;

  logic        clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [31:0] a = '0, b = '0;
  logic [3:0]  tag = '0;
  logic        busy, done;
  logic [31:0] result;
  logic [3:0]  tag_out;

  divsqrt_unit u_divsqrt_unit (
    .clk(clk), .rst(rst), .start_i(start), .op_i(op), .a_i(a), .b_i(b),
    .tag_i(tag), .busy_o(busy), .done_o(done), .result_o(result), .tag_o(tag_out)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    logic [31:0] res;
    logic [3:0]  tag;
    longint      acc;
    int          lat;
    string       req;
  } item_t;

  item_t  sb[$];
  int     errors = 0, checks = 0, issued = 0, completed = 0;
  longint cyc = 0;
  logic   prev_done = 1'b0;
  logic [31:0] last_res = '0;
  bit     finished = 0;

  always @(posedge clk) cyc++;

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int lat_of(logic [2:0] o);
    case (o)
      3'd0: return 17;
      3'd1: return 16;
      3'd2, 3'd3: return 22;
      default: return 23;
    endcase
  endfunction

  function automatic logic [31:0] ref_model(logic [2:0] o, logic [31:0] x, logic [31:0] y);
    logic s;
    longint ma, mb, qv, rv, r, t, e, eh;
    int sx, sy;
    ma = longint'({1'b1, x[22:0]});
    mb = longint'({1'b1, y[22:0]});
    sx = x; sy = y;
    case (o)
      3'd0: begin
        s = x[31] ^ y[31];
        if (y[30:23] == 0) return {s, 8'hFF, 23'd0};
        if (x[30:23] == 0) return {s, 31'd0};
        qv = (ma << 26) / mb;
        e  = longint'(x[30:23]) - longint'(y[30:23]) + 126 + ((qv >> 26) & 1);
        if (e >= 255) return {s, 8'hFF, 23'd0};
        if (e <= 0)   return {s, 31'd0};
        if (((qv >> 26) & 1) == 1) return {s, e[7:0], qv[25:3]};
        return {s, e[7:0], qv[24:2]};
      end
      3'd1: begin
        if (x[30:23] == 0) return {x[31], 31'd0};
        if (x[31]) return 32'h7FC00000;
        e = longint'(x[30:23]) - 127;
        if (e % 2 == 0) begin rv = ma << 23; eh = e / 2; end
        else begin rv = ma << 24; eh = (e - 1) / 2; end
        r = 0;
        for (int i = 24; i >= 0; i--) begin
          t = r | (longint'(1) << i);
          if (t * t <= rv) r = t;
        end
        eh = eh + 127;
        return {1'b0, eh[7:0], r[22:0]};
      end
      3'd2: begin
        if (y == 0) return 32'hFFFFFFFF;
        if (x == 32'h80000000 && y == 32'hFFFFFFFF) return 32'h80000000;
        return sx / sy;
      end
      3'd3: return (y == 0) ? 32'hFFFFFFFF : x / y;
      3'd4: begin
        if (y == 0) return x;
        if (x == 32'h80000000 && y == 32'hFFFFFFFF) return 32'd0;
        return sx % sy;
      end
      default: return (y == 0) ? x : x % y;
    endcase
  endfunction

  task automatic issue(logic [2:0] o, logic [31:0] x, logic [31:0] y, logic [3:0] tg, string req);
    item_t it;
    @(negedge clk);
    while (busy) @(negedge clk);
    start = 1'b1; op = o; a = x; b = y; tag = tg;
    @(posedge clk);
    #1;
    it.res = ref_model(o, x, y);
    it.tag = tg;
    it.acc = cyc;
    it.lat = lat_of(o);
    it.req = req;
    sb.push_back(it);
    issued++;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R2", "busy after accept", {31'd0, busy}, 32'd1);
  endtask

  task automatic wait_idle();
    while (sb.size() != 0 || busy) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (done && prev_done)
        chk(1'b0, "R2", "done longer than one cycle", 32'd2, 32'd1);
      if (done) begin
        completed++;
        if (sb.size() == 0) begin
          chk(1'b0, "R1", "done with nothing in flight", result, 32'd0);
        end else begin
          item_t it;
          it = sb.pop_front();
          chk(result === it.res, it.req, "result", result, it.res);
          chk(tag_out === it.tag, "R5", "tag", {28'd0, tag_out}, {28'd0, it.tag});
          chk(cyc - it.acc == it.lat, "R3", "latency", 32'(cyc - it.acc), 32'(it.lat));
          chk(busy === 1'b0, "R2", "busy low on done", {31'd0, busy}, 32'd0);
          last_res = it.res;
        end
      end
    end
    prev_done = done;
  end

  always @(posedge clk) begin
    if (cyc > 20000 && !finished) begin
      errors++; checks++;
      $display("FAIL watchdog (all) actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R13 reset state
    chk(busy === 1'b0 && done === 1'b0, "R13", "busy/done after reset", {30'd0, busy, done}, 32'd0);
    chk(result === 32'd0, "R13", "result after reset", result, 32'd0);
    chk(tag_out === 4'd0, "R13", "tag after reset", {28'd0, tag_out}, 32'd0);

    // R4 invalid opcodes
    for (int k = 6; k < 8; k++) begin
      start = 1'b1; op = 3'(k); a = 32'd9; b = 32'd3;
      @(negedge clk);
      start = 1'b0;
      chk(busy === 1'b0, "R4", "invalid opcode dropped", {31'd0, busy}, 32'd0);
    end

    // R6 unsigned
    issue(3'd3, 32'd100, 32'd7, 4'd1, "R6");
    issue(3'd5, 32'd100, 32'd7, 4'd2, "R6");
    issue(3'd3, 32'hFFFFFFFF, 32'd3, 4'd3, "R6");
    issue(3'd5, 32'hFFFFFFFF, 32'h10000, 4'd4, "R6");
    // R7 signed
    issue(3'd2, -32'sd7, 32'd2, 4'd5, "R7");
    issue(3'd4, -32'sd7, 32'd2, 4'd6, "R7");
    issue(3'd2, 32'd7, -32'sd2, 4'd7, "R7");
    issue(3'd4, 32'd7, -32'sd2, 4'd8, "R7");
    issue(3'd2, 32'h80000000, 32'hFFFFFFFF, 4'd9, "R7");
    issue(3'd4, 32'h80000000, 32'hFFFFFFFF, 4'd10, "R7");
    // R8 divide by zero
    issue(3'd2, -32'sd13, 32'd0, 4'd11, "R8");
    issue(3'd3, 32'd13, 32'd0, 4'd12, "R8");
    issue(3'd4, -32'sd13, 32'd0, 4'd13, "R8");
    issue(3'd5, 32'd13, 32'd0, 4'd14, "R8");
    // R9 float divide
    issue(3'd0, 32'h40C00000, 32'h40000000, 4'd1, "R9");
    issue(3'd0, 32'h3F800000, 32'h40400000, 4'd2, "R9");
    issue(3'd0, 32'hC1200000, 32'h3FC00000, 4'd3, "R9");
    issue(3'd0, 32'h3FC00000, 32'hBF400000, 4'd4, "R9");
    // R10 float divide specials
    issue(3'd0, 32'h3F800000, 32'h00000000, 4'd5, "R10");
    issue(3'd0, 32'hBF800000, 32'h00000000, 4'd6, "R10");
    issue(3'd0, 32'h00000000, 32'h40000000, 4'd7, "R10");
    issue(3'd0, 32'h7F000000, 32'h3E800000, 4'd8, "R10");
    issue(3'd0, 32'h00800000, 32'h40000000, 4'd9, "R10");
    // R11 square root
    issue(3'd1, 32'h40800000, 32'd0, 4'd10, "R11");
    issue(3'd1, 32'h40000000, 32'd0, 4'd11, "R11");
    issue(3'd1, 32'h3F000000, 32'd0, 4'd12, "R11");
    issue(3'd1, 32'h3E800000, 32'd0, 4'd13, "R11");
    issue(3'd1, 32'h4B7FFFFF, 32'd0, 4'd14, "R11");
    // R12 square root specials
    issue(3'd1, 32'hC0800000, 32'd0, 4'd15, "R12");
    issue(3'd1, 32'h80000000, 32'd0, 4'd0, "R12");
    issue(3'd1, 32'h00000000, 32'd0, 4'd1, "R12");
    wait_idle();

    // R1 start while busy is ignored
    issue(3'd3, 32'd1000, 32'd9, 4'd3, "R1");
    start = 1'b1; op = 3'd4; a = 32'd5; b = 32'd2; tag = 4'd9;
    repeat (4) @(negedge clk);
    start = 1'b0;
    wait_idle();
    repeat (40) @(negedge clk);
    chk(completed == issued, "R1", "completions equal accepted starts", 32'(completed), 32'(issued));
    // R5 result and tag held after done
    chk(result === last_res, "R5", "result held", result, last_res);
    chk(tag_out === 4'd3, "R5", "tag held", {28'd0, tag_out}, 32'd3);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule